// File: doc/BRIEF.md
# ADC Sequencer Status and Interrupt Logic

This block holds the status word of an ADC conversion sequencer and drives its interrupt line. The sequencer engine reports what happens through single-cycle event pulses: a sequence has finished, the last instruction of a sequence has completed, the sequence timer has run out, and a start was requested while the instruction memory is empty. A level input reports that a sequence is in progress. From these pulses the block keeps four sticky flags. Software reads them through a single 32-bit register port and clears each one by writing 1 to its bit.

The operating mode decides which flags may set and which of them may interrupt. The mode is timer-driven, continuous (timer value of zero), or external trigger. In continuous mode the overflow and timer flags are held at zero. The data-available flag still sets in that mode but does not interrupt. A read-only pending bit mirrors the interrupt output, so software can poll instead of waiting on the line. The interrupt is acknowledged by clearing the flags that caused it.

Top module: `adcseq_status`

## Requirements
- R1: After a synchronous reset, every status bit is 0, `irq` is 0 and `rdata` is 0.
- R2: Bit 0 (data available) sets on the clock edge that samples `ev_seq_done`. A write with bit 0 of `wdata` at 1 clears it. A write with that bit at 0 leaves it unchanged.
- R3: Bit 1 (overflow) sets when `ev_last_instr` is sampled while bit 0 is already 1 from an earlier edge. If bit 0 is 0 at that edge, bit 1 does not set. A write of 1 to bit 1 clears it.
- R4: Bit 2 (timer error) sets when `ev_timer_elapsed` is sampled while `seq_busy` is 1. The event has no effect while `seq_busy` is 0. A write of 1 to bit 2 clears it.
- R5: Bit 3 (empty instruction memory) sets when `ev_start_empty` is sampled, in every mode. A write of 1 to bit 3 clears it.
- R6: The `mode` encoding is 2'b00 timer-driven, 2'b01 continuous and 2'b10 external trigger; 2'b11 behaves as timer-driven. While `mode` is 2'b01, bits 1 and 2 read as 0 and cannot set. A value held from an earlier mode is dropped on the first edge in continuous mode.
- R7: `irq` is 1 exactly when a set flag is allowed to interrupt. In continuous mode only bit 3 is allowed. In the other modes bits 0 to 3 are all allowed.
- R8: Bit 4 reads the current value of `irq`. Writes to bit 4 and to bits 31:5 have no effect, and bits 31:5 always read as 0.
- R9: When a flag's set event and a write-1 clear of that flag are sampled on the same edge, the flag ends up set.
- R10: `rdata` is loaded on the edge that samples `rd_en`, with the status as it stood just before that edge. `rdata` holds its value while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Operating mode (encoding in R6) |
| ev_seq_done | input | 1 | Pulse: sequence done, new results stored |
| ev_last_instr | input | 1 | Pulse: final sequencer instruction completed |
| ev_timer_elapsed | input | 1 | Pulse: sequencer timer expired |
| seq_busy | input | 1 | Level: a sequence is in progress |
| ev_start_empty | input | 1 | Pulse: start requested with empty instruction memory |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Write data; a 1 in bits 3:0 clears that flag |
| rd_en | input | 1 | Register read strobe |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
A flag and `irq` change on the edge that samples their event or clear, so both are compared one time unit after that edge. `rdata` is also updated on the sampling edge, but it carries the status from before that edge. The expected read value is therefore taken from the bench model before the model applies the same cycle's events. Each stimulus is driven just after an edge and held for one full cycle, so every expected value refers to exactly one sampling edge. The sweep covers every event combination, both values of `seq_busy` and several clear masks in all four mode codes.

// File: rtl/seqstat_pkg.sv
package seqstat_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_FLAGS = 4;
    localparam int IRQ_BIT   = NUM_FLAGS;
    localparam int RSVD_W    = REG_W - NUM_FLAGS - 1;

    localparam int FLG_DAV  = 0;
    localparam int FLG_OVF  = 1;
    localparam int FLG_TMR  = 2;
    localparam int FLG_IMEM = 3;

    typedef enum logic [1:0] {
        SQM_TIMED   = 2'b00,
        SQM_CONT    = 2'b01,
        SQM_EXTTRIG = 2'b10,
        SQM_SPARE   = 2'b11
    } seq_mode_e;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    typedef struct packed {
        logic is_cont;
        flag_vec_t hold_zero;
        flag_vec_t irq_allow;
    } mode_ctl_t;

    function automatic logic [REG_W-1:0] pack_status(input flag_vec_t f, input logic pend);
        logic [REG_W-1:0] w;
        w = '0;
        w[NUM_FLAGS-1:0] = f;
        w[IRQ_BIT] = pend;
        return w;
    endfunction

endpackage

// File: rtl/seqstat_mode_ctl.sv
module seqstat_mode_ctl
    import seqstat_pkg::*;
(
    input  logic [1:0] mode,
    output mode_ctl_t  ctl
);
    seq_mode_e m;

    always_comb begin
        m = seq_mode_e'(mode);
        ctl.is_cont   = (m == SQM_CONT);
        ctl.hold_zero = '0;
        ctl.irq_allow = '1;
        if (ctl.is_cont) begin
            ctl.hold_zero[FLG_OVF] = 1'b1;
            ctl.hold_zero[FLG_TMR] = 1'b1;
            ctl.irq_allow          = '0;
            ctl.irq_allow[FLG_IMEM] = 1'b1;
        end
    end
endmodule

// File: rtl/seqstat_flag_bank.sv
module seqstat_flag_bank
    import seqstat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t set_vec,
    input  flag_vec_t clr_vec,
    input  flag_vec_t hold_zero,
    output flag_vec_t flags_q
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags_q[i] <= 1'b0;
            else if (hold_zero[i])
                flags_q[i] <= 1'b0;
            else if (set_vec[i])
                flags_q[i] <= 1'b1;
            else if (clr_vec[i])
                flags_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/seqstat_read_port.sv
module seqstat_read_port
    import seqstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  flag_vec_t        flags_vis,
    input  logic             pend,
    output logic [REG_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= pack_status(flags_vis, pend);
    end
endmodule

// File: rtl/adcseq_status.sv
module adcseq_status
    import seqstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             ev_seq_done,
    input  logic             ev_last_instr,
    input  logic             ev_timer_elapsed,
    input  logic             seq_busy,
    input  logic             ev_start_empty,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             rd_en,
    output logic [REG_W-1:0] rdata,
    output logic             irq
);
    mode_ctl_t ctl;
    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    flag_vec_t flags_q;
    flag_vec_t flags_vis;

    seqstat_mode_ctl u_mode (
        .mode (mode),
        .ctl  (ctl)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FLG_DAV]  = ev_seq_done;
        set_vec[FLG_OVF]  = ev_last_instr & flags_q[FLG_DAV];
        set_vec[FLG_TMR]  = ev_timer_elapsed & seq_busy;
        set_vec[FLG_IMEM] = ev_start_empty;
        clr_vec           = wr_en ? wdata[NUM_FLAGS-1:0] : '0;
    end

    seqstat_flag_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .hold_zero (ctl.hold_zero),
        .flags_q   (flags_q)
    );

    // Flags held from an earlier mode stay hidden during the first continuous cycle
    assign flags_vis = flags_q & ~ctl.hold_zero;
    assign irq       = |(flags_vis & ctl.irq_allow);

    seqstat_read_port u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .flags_vis (flags_vis),
        .pend      (irq),
        .rdata     (rdata)
    );
endmodule

// File: rtl/adcseq_status_chk.sv
module adcseq_status_chk
    import seqstat_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input logic             ev_seq_done,
    input logic             ev_last_instr,
    input logic             ev_timer_elapsed,
    input logic             seq_busy,
    input logic             ev_start_empty,
    input logic             rd_en,
    input logic [REG_W-1:0] rdata,
    input logic             irq,
    input flag_vec_t        flags_q
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (flags_q == '0 && !irq && rdata == '0));

    assert_dav_sets_R2: assert property (@(posedge clk) disable iff (rst)
        ev_seq_done |=> flags_q[FLG_DAV]);

    assert_tmr_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (ev_timer_elapsed && seq_busy && mode != 2'b01) |=> flags_q[FLG_TMR]);

    assert_imem_sets_R5: assert property (@(posedge clk) disable iff (rst)
        ev_start_empty |=> flags_q[FLG_IMEM]);

    assert_cont_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |=> (flags_q[FLG_TMR:FLG_OVF] == 2'b00));

    assert_cont_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && !flags_q[FLG_IMEM]) |-> !irq);

    assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (rst)
        rdata[REG_W-1:IRQ_BIT+1] == '0);

    assert_rd_pend_R10: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (rdata[IRQ_BIT] == $past(irq)));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

bind adcseq_status adcseq_status_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .mode             (mode),
    .ev_seq_done      (ev_seq_done),
    .ev_last_instr    (ev_last_instr),
    .ev_timer_elapsed (ev_timer_elapsed),
    .seq_busy         (seq_busy),
    .ev_start_empty   (ev_start_empty),
    .rd_en            (rd_en),
    .rdata            (rdata),
    .irq              (irq),
    .flags_q          (flags_q)
);

// File: tb/tb_adcseq_status.sv
`timescale 1ns/1ps
module tb_adcseq_status;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic        ev_seq_done, ev_last_instr, ev_timer_elapsed, seq_busy, ev_start_empty;
    logic        wr_en, rd_en;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [3:0]  mdl;
    logic [31:0] last_rd;

    always #2 clk = ~clk;

    adcseq_status dut (
        .clk(clk), .rst(rst), .mode(mode),
        .ev_seq_done(ev_seq_done), .ev_last_instr(ev_last_instr),
        .ev_timer_elapsed(ev_timer_elapsed), .seq_busy(seq_busy),
        .ev_start_empty(ev_start_empty), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .irq(irq)
    );

    function automatic logic [3:0] vis(input logic [3:0] f, input logic [1:0] m);
        return (m == 2'b01) ? (f & 4'b1001) : f;
    endfunction

    function automatic logic irq_of(input logic [3:0] f, input logic [1:0] m);
        return (m == 2'b01) ? f[3] : |f;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive_idle();
        ev_seq_done = 0; ev_last_instr = 0; ev_timer_elapsed = 0;
        ev_start_empty = 0; wr_en = 0; rd_en = 0; wdata = '0;
    endtask

    // ev: [0] seq done, [1] last instr, [2] timer elapsed, [3] start empty
    task automatic step(input logic [1:0] m, input logic [3:0] ev, input logic busy,
                        input logic wr, input logic [31:0] wd, input logic rd, input string tag);
        logic [31:0] exp_rd;
        logic [3:0]  clr;
        logic [3:0]  nx;
        mode = m;
        ev_seq_done = ev[0]; ev_last_instr = ev[1]; ev_timer_elapsed = ev[2];
        ev_start_empty = ev[3]; seq_busy = busy;
        wr_en = wr; wdata = wd; rd_en = rd;
        exp_rd = {27'b0, irq_of(vis(mdl, m), m), vis(mdl, m)};
        clr = wr ? wd[3:0] : 4'b0;
        nx[0] = ev[0] | (mdl[0] & ~clr[0]);
        nx[1] = (ev[1] & mdl[0]) | (mdl[1] & ~clr[1]);
        nx[2] = (ev[2] & busy) | (mdl[2] & ~clr[2]);
        nx[3] = ev[3] | (mdl[3] & ~clr[3]);
        if (m == 2'b01) nx[2:1] = 2'b00;
        mdl = nx;
        @(posedge clk); #1;
        if (rd) last_rd = exp_rd;
        chk({tag, " irq"}, {31'b0, irq}, {31'b0, irq_of(vis(mdl, m), m)});
        chk({tag, " rdata"}, rdata, last_rd);
        drive_idle();
    endtask

    task automatic rd_now(input logic [1:0] m, input string tag);
        step(m, 4'b0, 1'b0, 1'b0, 32'b0, 1'b1, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_vec++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        mdl = '0; last_rd = '0;
        rst = 1; mode = 2'b00; seq_busy = 0;
        drive_idle();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        chk("R1 reset rdata", rdata, 32'b0);
        chk("R1 reset irq", {31'b0, irq}, 32'b0);
        rd_now(2'b00, "R1 read after reset");

        // R2 data available set/clear
        step(2'b00, 4'b0001, 0, 0, 0, 0, "R2 set");
        rd_now(2'b00, "R2 read set");
        step(2'b00, 4'b0, 0, 1, 32'h0000_000E, 1, "R2 write0 keeps");
        rd_now(2'b00, "R2 read kept");
        step(2'b00, 4'b0, 0, 1, 32'h1, 0, "R2 clear");
        rd_now(2'b00, "R2 read cleared");

        // R3 overflow needs data-available already set
        step(2'b00, 4'b0011, 0, 0, 0, 0, "R3 no ovf same edge");
        rd_now(2'b00, "R3 read no ovf");
        step(2'b10, 4'b0010, 0, 0, 0, 0, "R3 ovf sets");
        rd_now(2'b10, "R3 read ovf");
        step(2'b10, 4'b0, 0, 1, 32'h3, 1, "R3 clear");
        rd_now(2'b10, "R3 read cleared");

        // R4 timer error needs busy
        step(2'b00, 4'b0100, 0, 0, 0, 0, "R4 idle no set");
        rd_now(2'b00, "R4 read none");
        step(2'b00, 4'b0100, 1, 0, 0, 0, "R4 busy sets");
        rd_now(2'b00, "R4 read set");

        // R6 entering continuous mode drops timer error, blocks new sets
        step(2'b01, 4'b0, 0, 0, 0, 1, "R6 first cont cycle");
        rd_now(2'b01, "R6 read zero");
        step(2'b01, 4'b0111, 1, 0, 0, 0, "R6 no ovf/tmr");
        rd_now(2'b01, "R6 read cont");

        // R7 data available in continuous mode: no irq
        chk("R7 cont dav no irq", {31'b0, irq}, 32'b0);
        step(2'b01, 4'b1000, 0, 0, 0, 0, "R5 imem sets in cont");
        chk("R7 cont imem irq", {31'b0, irq}, 32'b1);
        rd_now(2'b01, "R5 read");

        // R8 writes to pending bit and reserved bits ignored
        step(2'b01, 4'b0, 0, 1, 32'hFFFF_FFF0, 0, "R8 high write");
        rd_now(2'b01, "R8 read pend");
        step(2'b00, 4'b0, 0, 1, 32'hF, 0, "R8 clear all");
        rd_now(2'b00, "R8 read zero");

        // R9 set beats clear
        step(2'b00, 4'b1001, 0, 1, 32'h9, 0, "R9 set wins");
        rd_now(2'b00, "R9 read");

        // R10 rdata holds without strobe
        step(2'b00, 4'b0100, 1, 0, 0, 0, "R10 hold 1");
        step(2'b00, 4'b0, 0, 1, 32'hF, 0, "R10 hold 2");
        rd_now(2'b00, "R10 read after hold");

        // sweep: all mode codes, event combos, busy, varying clear masks
        for (int m = 0; m < 4; m++)
            for (int e = 0; e < 16; e++)
                for (int b = 0; b < 2; b++)
                    for (int c = 0; c < 3; c++) begin
                        logic [3:0] msk;
                        msk = 4'((e * 5 + m + c * 7) & 15);
                        step(2'(m), 4'(e), b[0], c != 0, {28'hFFFFFFF, msk}, 1'b1, "R7 R10 sweep");
                    end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule